// File: doc/BRIEF.md
# SPI Slave Pause (HOLD) Front-End

This block sits between the pins of an SPI slave and its command engine. It brings chip select, serial clock, serial input and the active-low pause request into the system clock domain through two-flop synchronizers. It then hands the engine qualified serial-clock edge pulses together with the current serial input bit. In the other direction it returns the engine's serial output data and drive enable toward the pin.

A master can pause a transaction part-way through by pulling the pause request low. While paused, clock edges and input data are withheld from the engine and the output driver is switched off. The engine keeps its state, so the transfer carries on from the bit where it stopped once the pause ends. Entering and leaving the pause depend on the serial clock level. A request made while the clock is high takes effect only at the next clock fall. A release made while the clock is high waits until the clock is low. Deselecting the slave cancels any pause and pulses a clear toward the engine.

Top module: `spi_hold_gate`

## Requirements
- R1: While the slave is selected and not paused, each rising serial-clock edge on the pin produces exactly one `sck_rise` pulse, and `si_bit` during that pulse equals the level sampled on `si_pin`. Each falling edge produces one `sck_fall` pulse.
- R2: A pause request (`hold_n_pin` low) made while the serial clock is low sets `paused` within four system clocks, with no further clock edge needed.
- R3: A pause request made while the serial clock is high leaves `paused` at 0 until the serial clock falls. That falling edge is still forwarded as a `sck_fall` pulse, and `paused` is set after it.
- R4: While `paused` is 1, no `sck_rise` or `sck_fall` pulse is produced, whatever the serial clock and input do.
- R5: Whenever the synchronized pause request is low, `so_oe` is 0.
- R6: Releasing the pause while the serial clock is high keeps `paused` at 1 until the clock goes low. The falling edge that ends the wait is not forwarded.
- R7: After a pause ends, the next forwarded rising edge carries the next input bit, so no bit is lost or repeated across the pause.
- R8: Raising `cs_n_pin` clears `paused` and produces one `eng_clear` pulse toward the engine. `sel` follows the inverted, synchronized chip select.
- R9: While selected, running and not pause-requested, `so_oe` equals `eng_so_en`, and `so_out` equals `eng_so` whenever `so_oe` is 1.
- R10: While deselected, no clock edge pulse is produced and `so_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_pin | input | 1 | Chip select pin, active low |
| sck_pin | input | 1 | Serial clock pin |
| si_pin | input | 1 | Serial data input pin |
| hold_n_pin | input | 1 | Pause request pin, active low |
| eng_so | input | 1 | Serial output bit from the engine |
| eng_so_en | input | 1 | Output drive request from the engine |
| sel | output | 1 | Synchronized select, active high |
| sck_rise | output | 1 | One-cycle pulse per forwarded rising clock edge |
| sck_fall | output | 1 | One-cycle pulse per forwarded falling clock edge |
| si_bit | output | 1 | Synchronized serial input bit |
| eng_clear | output | 1 | One-cycle pulse when the slave is deselected |
| paused | output | 1 | Transfer is currently paused |
| so_out | output | 1 | Serial output value for the pin |
| so_oe | output | 1 | Serial output drive enable for the pin |

## Verification
The hardest situations to reach are the two deferred transitions. In one, the pause request lands while the serial clock is high. In the other, it is released while the clock is high. Both need the clock level and the request to be ordered on purpose. The stimulus parks the serial clock high, moves the request, holds both steady for several system clocks to show that nothing has changed yet, and only then drops the clock. Bits sent before and after each pause go through a scoreboard queue, so a lost, repeated or leaked edge shows up as a mismatch or an unexpected pulse.

// File: rtl/spi_hold_gate_pkg.sv
package spi_hold_gate_pkg;
  typedef enum logic [1:0] {
    ST_RUN         = 2'd0,
    ST_ENTER_WAIT  = 2'd1,
    ST_PAUSED      = 2'd2,
    ST_RESUME_WAIT = 2'd3
  } hold_state_e;

  localparam int unsigned PIN_CNT = 4;
  localparam int unsigned IDX_CS   = 0;
  localparam int unsigned IDX_SCK  = 1;
  localparam int unsigned IDX_SI   = 2;
  localparam int unsigned IDX_HOLD = 3;
endpackage

// File: rtl/hg_sync.sv
module hg_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hg_edge.sv
module hg_edge #(
  parameter int unsigned W = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) d_q <= RST_VAL;
    else        d_q <= d;
  end

  assign rise = d & ~d_q;
  assign fall = ~d & d_q;
endmodule

// File: rtl/hg_hold_fsm.sv
module hg_hold_fsm
  import spi_hold_gate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic sck,
  input  logic hold_n,
  output logic pass,
  output logic paused,
  output logic running
);
  hold_state_e state, nxt;

  always_comb begin
    nxt = state;
    if (!sel) begin
      nxt = ST_RUN;
    end else begin
      unique case (state)
        ST_RUN:         if (!hold_n) nxt = sck ? ST_ENTER_WAIT : ST_PAUSED;
        ST_ENTER_WAIT:  if (hold_n) nxt = ST_RUN;
                        else if (!sck) nxt = ST_PAUSED;
        ST_PAUSED:      if (hold_n) nxt = sck ? ST_RESUME_WAIT : ST_RUN;
        ST_RESUME_WAIT: if (!hold_n) nxt = ST_PAUSED;
                        else if (!sck) nxt = ST_RUN;
        default:        nxt = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RUN;
    else        state <= nxt;
  end

  assign pass    = (state == ST_RUN) || (state == ST_ENTER_WAIT);
  assign paused  = (state == ST_PAUSED) || (state == ST_RESUME_WAIT);
  assign running = (state == ST_RUN);
endmodule

// File: rtl/spi_hold_gate.sv
module spi_hold_gate
  import spi_hold_gate_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_pin,
  input  logic sck_pin,
  input  logic si_pin,
  input  logic hold_n_pin,
  input  logic eng_so,
  input  logic eng_so_en,
  output logic sel,
  output logic sck_rise,
  output logic sck_fall,
  output logic si_bit,
  output logic eng_clear,
  output logic paused,
  output logic so_out,
  output logic so_oe
);
  localparam logic [PIN_CNT-1:0] PIN_IDLE = 4'b1001;

  logic [PIN_CNT-1:0] pins_raw, pins_s;
  logic [1:0] edge_in, edge_r, edge_f;
  logic s_cs_n, s_sck, s_hold_n;
  logic pass, running;

  assign pins_raw[IDX_CS]   = cs_n_pin;
  assign pins_raw[IDX_SCK]  = sck_pin;
  assign pins_raw[IDX_SI]   = si_pin;
  assign pins_raw[IDX_HOLD] = hold_n_pin;

  hg_sync #(.W(PIN_CNT), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) i_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s)
  );

  assign s_cs_n   = pins_s[IDX_CS];
  assign s_sck    = pins_s[IDX_SCK];
  assign s_hold_n = pins_s[IDX_HOLD];
  assign si_bit   = pins_s[IDX_SI];
  assign sel      = ~s_cs_n;

  assign edge_in = {s_cs_n, s_sck};

  hg_edge #(.W(2), .RST_VAL(2'b10)) i_edge (
    .clk(clk), .rst_n(rst_n), .d(edge_in), .rise(edge_r), .fall(edge_f)
  );

  hg_hold_fsm i_fsm (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sck(s_sck), .hold_n(s_hold_n),
    .pass(pass), .paused(paused), .running(running)
  );

  assign sck_rise  = sel & pass & edge_r[0];
  assign sck_fall  = sel & pass & edge_f[0];
  assign eng_clear = edge_r[1];
  assign so_oe     = sel & s_hold_n & running & eng_so_en;
  assign so_out    = so_oe & eng_so;
endmodule

// File: rtl/spi_hold_gate_chk.sv
module spi_hold_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic hold_n_pin,
  input logic eng_so,
  input logic sel,
  input logic sck_rise,
  input logic sck_fall,
  input logic paused,
  input logic so_out,
  input logic so_oe
);
  // R4
  paused_no_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> !sck_rise && !sck_fall);
  // R5
  hold_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_n_pin && $past(!hold_n_pin) && $past(!hold_n_pin, 2)) |-> !so_oe);
  // R8
  desel_unpause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !paused);
  // R10
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> !so_oe && !sck_rise && !sck_fall);
  // R9
  so_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> so_out == eng_so);
  // R1
  edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sck_rise && sck_fall));
endmodule

bind spi_hold_gate spi_hold_gate_chk i_chk (
  .clk(clk), .rst_n(rst_n), .hold_n_pin(hold_n_pin), .eng_so(eng_so),
  .sel(sel), .sck_rise(sck_rise), .sck_fall(sck_fall), .paused(paused),
  .so_out(so_out), .so_oe(so_oe)
);

// File: tb/test_spi_hold_gate.sv
module test_spi_hold_gate;
  logic clk = 0, rst_n = 0;
  logic cs_n_pin = 1, sck_pin = 0, si_pin = 0, hold_n_pin = 1;
  logic eng_so = 0, eng_so_en = 0;
  logic sel, sck_rise, sck_fall, si_bit, eng_clear, paused, so_out, so_oe;

  int n_chk = 0, n_fail = 0;
  int fall_cnt = 0, clear_cnt = 0;
  bit exp_q[$];

  always #10 clk = ~clk;

  spi_hold_gate i_spi_hold_gate (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one bit: clock low with data, rise, fall; expects it forwarded
  task automatic send_bit(input bit b);
    si_pin = b; idle(5);
    exp_q.push_back(b);
    sck_pin = 1; idle(5);
    sck_pin = 0; idle(5);
  endtask

  // monitor: pops the scoreboard on every forwarded rise
  always @(negedge clk) begin
    if (rst_n) begin
      if (sck_rise) begin
        if (exp_q.size() == 0) begin
          chk(0, "R4 unexpected rise", 1, 0);
        end else begin
          bit e;
          e = exp_q.pop_front();
          chk(si_bit == e, "R1/R7 si_bit", si_bit, e);
        end
      end
      if (sck_fall) fall_cnt++;
      if (eng_clear) clear_cnt++;
    end
  end

  initial begin
    #4_000_000;
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int f0;
    idle(3);
    chk(paused == 0 && so_oe == 0 && sck_rise == 0, "reset", paused, 0);
    rst_n = 1; idle(4);
    // R10: deselected edges ignored
    sck_pin = 1; idle(5); sck_pin = 0; idle(5);
    chk(fall_cnt == 0 && so_oe == 0, "R10 deselected", fall_cnt, 0);
    chk(sel == 0, "R8 sel idle", sel, 0);
    cs_n_pin = 0; idle(5);
    chk(sel == 1, "R8 sel", sel, 1);
    // R9
    eng_so_en = 1; eng_so = 1; idle(2);
    chk(so_oe == 1 && so_out == 1, "R9 so drive", so_out, 1);
    eng_so = 0; idle(2);
    chk(so_out == 0, "R9 so low", so_out, 0);
    eng_so_en = 0; idle(2);
    chk(so_oe == 0, "R9 so off", so_oe, 0);
    eng_so_en = 1; eng_so = 1;
    // R1
    send_bit(1); send_bit(0); send_bit(1); send_bit(1);
    chk(exp_q.size() == 0 && fall_cnt == 4, "R1 bits", fall_cnt, 4);
    // R2: pause with sck low
    hold_n_pin = 0; idle(4);
    chk(paused == 1, "R2 pause at once", paused, 1);
    chk(so_oe == 0, "R5 so off in pause", so_oe, 0);
    // R4: toggles ignored
    for (int i = 0; i < 3; i++) begin
      si_pin = ~si_pin; sck_pin = 1; idle(5); sck_pin = 0; idle(5);
    end
    chk(fall_cnt == 4, "R4 no edges", fall_cnt, 4);
    // R6: release while sck high
    sck_pin = 1; idle(5);
    hold_n_pin = 1; idle(6);
    chk(paused == 1, "R6 resume deferred", paused, 1);
    chk(so_oe == 0, "R6 so still off", so_oe, 0);
    sck_pin = 0; idle(6);
    chk(paused == 0 && fall_cnt == 4, "R6 resumed, fall hidden", fall_cnt, 4);
    chk(so_oe == 1, "R9 so back", so_oe, 1);
    // R7
    send_bit(0); send_bit(1);
    chk(exp_q.size() == 0, "R7 continued", exp_q.size(), 0);
    // R3: request while sck high
    si_pin = 1; idle(5); exp_q.push_back(1);
    sck_pin = 1; idle(5);
    hold_n_pin = 0; idle(6);
    chk(paused == 0, "R3 pause deferred", paused, 0);
    chk(so_oe == 0, "R5 so off while requested", so_oe, 0);
    f0 = fall_cnt;
    sck_pin = 0; idle(6);
    chk(fall_cnt == f0 + 1, "R3 fall forwarded", fall_cnt, f0 + 1);
    chk(paused == 1, "R3 paused after fall", paused, 1);
    sck_pin = 1; idle(5); sck_pin = 0; idle(5);
    chk(fall_cnt == f0 + 1, "R4 no edges 2", fall_cnt, f0 + 1);
    // R8: deselect during pause
    cs_n_pin = 1; idle(6);
    chk(paused == 0 && sel == 0, "R8 pause cleared", paused, 0);
    chk(clear_cnt == 1, "R8 clear pulse", clear_cnt, 1);
    hold_n_pin = 1; cs_n_pin = 0; idle(5);
    send_bit(0);
    chk(exp_q.size() == 0, "R1 after reselect", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule